// File: doc/BRIEF.md
# Word-Granular Next-PC Unit

This block keeps the program counter of a simple in-order core in word units and presents the byte fetch address to instruction memory. Instructions are four bytes long and always aligned, so the two lowest address bits carry no information. The register holds only the upper address bits, and the fetch address is that value with two zero bits appended below it.

Each cycle the unit works out the next counter value with one adder whose carry-in is always set. For straight-line code the adder's second operand is zero, so the counter advances by one word. For a taken conditional branch the second operand is the branch immediate, sign-extended to the counter width, so the result is one word past the current instruction plus the word offset. A branch is taken only when the decoder asserts the conditional-branch control and the datapath reports that its two register operands subtracted to zero. A hold input freezes the counter while the pipeline is stalled.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `pc_word` becomes 0 and `fetch_addr` becomes 0 after that edge.
- R2: `fetch_addr` always equals `pc_word` shifted left by two, with bits 1 and 0 at zero.
- R3: With `rst` 0, `hold` 0 and no branch taken, `pc_word` advances by exactly 1 at each edge (byte address plus 4).
- R4: A branch is taken only when `cond_branch` and `operands_equal` are both 1; with either one at 0 the counter follows sequential flow as in R3.
- R5: On a taken branch `pc_word` becomes the old `pc_word` + 1 + the sign-extended `br_imm` (byte address plus 4 plus four times the offset).
- R6: `br_imm` is a two's-complement word offset whose bit 15 is the sign, so a value with bit 15 set moves the counter backwards.
- R7: With `rst` 0 and `hold` 1, `pc_word` keeps its value whatever the branch inputs are.
- R8: All counter arithmetic wraps modulo 2^30; stepping past 0x3FFFFFFF gives 0 and a backward branch below 0 lands near the top, with no error indication.
- R9: `rst` takes priority over `hold`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freeze the counter this cycle (stall) |
| cond_branch | input | 1 | Current instruction is a conditional branch |
| operands_equal | input | 1 | Datapath zero flag: the two register operands subtract to zero |
| br_imm | input | 16 | Signed word offset of the branch |
| fetch_addr | output | 32 | Byte-aligned instruction fetch address |
| pc_word | output | 30 | Current program counter in word units |

## Verification
The bench builds the unit with its default widths, a 32-bit byte address and a 16-bit offset, so the counter is 30 bits wide. At that size a single branch of offset -2 from address zero reaches the top of the counter range and the following sequential step wraps back to zero, which makes the modulo behaviour reachable within a few cycles; offsets of the extreme values 0x7FFF and 0x8000 exercise the sign extension at both ends. Random stretches mix resets, holds and every combination of the two branch inputs against a behavioural model of the counter.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Default geometry of the fetch address.
    localparam int ADDR_W_DEF     = 32;
    localparam int ALIGN_BITS_DEF = 2;
    localparam int IMM_W_DEF      = 16;

    // Which way the counter moves this cycle.
    typedef enum logic [1:0] {
        FLOW_HOLD   = 2'd0,
        FLOW_SEQ    = 2'd1,
        FLOW_BRANCH = 2'd2
    } flow_e;

    // Control bundle from the decode stage to the operand selector.
    typedef struct packed {
        flow_e flow;
        logic  load;
    } npc_ctl_t;

    function automatic npc_ctl_t decide_flow(input logic stall,
                                             input logic is_branch,
                                             input logic is_zero);
        npc_ctl_t c;
        if (stall) begin
            c.flow = FLOW_HOLD;
            c.load = 1'b0;
        end else if (is_branch && is_zero) begin
            c.flow = FLOW_BRANCH;
            c.load = 1'b1;
        end else begin
            c.flow = FLOW_SEQ;
            c.load = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/npc_flow_decode.sv
module npc_flow_decode
    import npc_pkg::*;
(
    input  logic     hold,
    input  logic     cond_branch,
    input  logic     operands_equal,
    output npc_ctl_t ctl
);

    always_comb begin
        ctl = decide_flow(hold, cond_branch, operands_equal);
    end

endmodule

// File: rtl/npc_operand_sel.sv
module npc_operand_sel
    import npc_pkg::*;
#(
    parameter int PC_W  = 30,
    parameter int IMM_W = 16
) (
    input  flow_e             flow,
    input  logic [IMM_W-1:0]  imm,
    output logic [PC_W-1:0]   operand
);

    logic [PC_W-1:0] imm_ext;

    generate
        if (PC_W > IMM_W) begin : g_extend
            localparam int FILL_W = PC_W - IMM_W;
            assign imm_ext = {{FILL_W{imm[IMM_W-1]}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (flow)
            FLOW_BRANCH: operand = imm_ext;
            default:     operand = '0;
        endcase
    end

endmodule

// File: rtl/npc_adder.sv
module npc_adder #(
    parameter int W = 30
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);

    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int ALIGN_BITS = ALIGN_BITS_DEF,
    parameter int IMM_W      = IMM_W_DEF,
    localparam int PC_W      = ADDR_W - ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              cond_branch,
    input  logic              operands_equal,
    input  logic [IMM_W-1:0]  br_imm,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [PC_W-1:0]   pc_word
);

    npc_ctl_t        ctl;
    logic [PC_W-1:0] addend;
    logic [PC_W-1:0] pc_next;
    logic [PC_W-1:0] pc_q;

    npc_flow_decode u_decode (
        .hold           (hold),
        .cond_branch    (cond_branch),
        .operands_equal (operands_equal),
        .ctl            (ctl)
    );

    npc_operand_sel #(
        .PC_W  (PC_W),
        .IMM_W (IMM_W)
    ) u_opsel (
        .flow    (ctl.flow),
        .imm     (br_imm),
        .operand (addend)
    );

    // One shared incrementer; the constant carry-in supplies the +1 word.
    npc_adder #(
        .W (PC_W)
    ) u_add (
        .a   (pc_q),
        .b   (addend),
        .cin (1'b1),
        .sum (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (ctl.load) begin
            pc_q <= pc_next;
        end
    end

    assign pc_word    = pc_q;
    assign fetch_addr = {pc_q, {ALIGN_BITS{1'b0}}};

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2,
    parameter int IMM_W      = 16,
    parameter int PC_W       = ADDR_W - ALIGN_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic              hold,
    input logic              cond_branch,
    input logic              operands_equal,
    input logic [IMM_W-1:0]  br_imm,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [PC_W-1:0]   pc_word
);

    logic [PC_W-1:0] off_wide;
    assign off_wide = PC_W'($signed(br_imm));

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_word == '0)) else $error("reset did not clear"); // R1

    AST_ALIGNED_FETCH: assert property (@(posedge clk) disable iff (rst)
        (fetch_addr[ALIGN_BITS-1:0] == '0) && (fetch_addr[ADDR_W-1:ALIGN_BITS] == pc_word))
        else $error("fetch address misaligned"); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!hold && !(cond_branch && operands_equal)) |=> (pc_word == PC_W'($past(pc_word) + 1'b1)))
        else $error("sequential step wrong"); // R3

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        (!hold && cond_branch && operands_equal) |=>
        (pc_word == PC_W'($past(pc_word) + $past(off_wide) + 1'b1)))
        else $error("branch target wrong"); // R5

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(pc_word)) else $error("hold moved the counter"); // R7

endmodule

bind npc_unit npc_unit_chk #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS),
    .IMM_W      (IMM_W),
    .PC_W       (PC_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .hold           (hold),
    .cond_branch    (cond_branch),
    .operands_equal (operands_equal),
    .br_imm         (br_imm),
    .fetch_addr     (fetch_addr),
    .pc_word        (pc_word)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

    localparam int  ADDR_W = 32;
    localparam int  IMM_W  = 16;
    localparam int  PC_W   = 30;
    localparam longint MASK = (longint'(1) <<< PC_W) - 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic              rst = 1'b1;
    logic              hold = 1'b1;
    logic              cond_branch = 1'b0;
    logic              operands_equal = 1'b0;
    logic [IMM_W-1:0]  br_imm = '0;
    logic [ADDR_W-1:0] fetch_addr;
    logic [PC_W-1:0]   pc_word;

    npc_unit u_dut (
        .clk            (clk),
        .rst            (rst),
        .hold           (hold),
        .cond_branch    (cond_branch),
        .operands_equal (operands_equal),
        .br_imm         (br_imm),
        .fetch_addr     (fetch_addr),
        .pc_word        (pc_word)
    );

    // Behavioural reference model.
    longint ref_pc = 0;
    string  tag = "R1";
    int     vectors = 0;
    int     errs = 0;
    bit     checking = 1'b0;
    bit     done = 1'b0;

    always @(posedge clk) begin
        longint raw;
        if (rst) begin
            ref_pc <= 0;
            tag    <= hold ? "R9" : "R1";
        end else if (hold) begin
            tag <= "R7";
        end else if (cond_branch && operands_equal) begin
            raw = ref_pc + 1 + longint'($signed(br_imm));
            ref_pc <= raw & MASK;
            if (raw < 0 || raw > MASK) tag <= "R8";
            else if (br_imm[IMM_W-1])  tag <= "R6";
            else                       tag <= "R5";
        end else begin
            raw = ref_pc + 1;
            ref_pc <= raw & MASK;
            if (raw > MASK)                          tag <= "R8";
            else if (cond_branch || operands_equal)  tag <= "R4";
            else                                     tag <= "R3";
        end
    end

    always @(negedge clk) begin
        if (checking && !done) begin
            vectors++;
            if (pc_word !== ref_pc[PC_W-1:0]) begin
                errs++;
                $display("FAIL %s pc_word actual=%h expected=%h", tag, pc_word, ref_pc[PC_W-1:0]);
            end
            vectors++;
            if (fetch_addr !== {ref_pc[PC_W-1:0], 2'b00}) begin   // R2
                errs++;
                $display("FAIL R2 fetch_addr actual=%h expected=%h", fetch_addr,
                         {ref_pc[PC_W-1:0], 2'b00});
            end
        end
    end

    task automatic drive(input logic r, input logic h, input logic b,
                         input logic z, input logic [IMM_W-1:0] i);
        @(negedge clk);
        #1;
        rst = r; hold = h; cond_branch = b; operands_equal = z; br_imm = i;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    endtask

    initial begin
        // R9: reset asserted together with hold
        @(posedge clk);
        checking = 1'b1;
        drive(1, 1, 1, 1, 16'h0005);
        drive(1, 0, 0, 0, 16'h0000);                   // R1
        // R3: sequential steps
        repeat (4) drive(0, 0, 0, 0, 16'h1234);
        // R4: only one of the two branch inputs high
        drive(0, 0, 1, 0, 16'h0040);
        drive(0, 0, 0, 1, 16'h0040);
        // R5: forward taken branch
        drive(0, 0, 1, 1, 16'h0010);
        drive(0, 0, 1, 1, 16'h7FFF);
        // R6: backward taken branches
        drive(0, 0, 1, 1, 16'hFFF0);
        drive(0, 0, 1, 1, 16'h8000);
        // R7: hold with a taken-branch pattern and with sequential inputs
        drive(0, 1, 1, 1, 16'h0100);
        drive(0, 1, 0, 0, 16'h0000);
        // R8: wrap below zero and back over the top
        drive(1, 0, 0, 0, 16'h0000);
        drive(0, 0, 1, 1, 16'hFFFE);
        drive(0, 0, 0, 0, 16'h0000);
        drive(0, 0, 1, 1, 16'hFFFF);                   // branch to self
        drive(0, 0, 0, 0, 16'h0000);
        // R1: reset in mid-stream
        drive(1, 0, 1, 1, 16'h0007);
        drive(0, 0, 0, 0, 16'h0000);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            drive(($urandom % 50) == 0, ($urandom % 5) == 0,
                  $urandom % 2, $urandom % 2, IMM_W'($urandom));
        end
        drive(0, 0, 0, 0, 16'h0000);
        @(negedge clk);
        #2;
        finish_run();
    end

    initial begin
        #(20 * 200000);
        errs++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule